// File: doc/BRIEF.md
# Serial Port Register and Interrupt Unit

This block is the register file that a host processor sees for a 16550-compatible serial port. A byte-wide bus with a 4-bit address and separate read and write strobes reaches nine register offsets. The block holds the configuration that the transmit and receive bit engines use: word length, stop bits, parity, break, the baud divisor, FIFO enable and receive trigger, and the mode selector. It drives the data-terminal-ready and request-to-send outputs. It also issues one-cycle push, pop and clear strobes to the transmit and receive FIFOs, which sit outside the block.

Status comes in from the transmitter, the receiver and four modem pins. The block gathers the error and change events into sticky flags. It ranks the pending causes into a 4-bit identification code and drives one level-sensitive interrupt line. The reads that report a cause also clear it. In loopback mode the modem status reflects the block's own modem control bits, and the physical pins are ignored.

Top module: `uart_regfile`

## Requirements
- R1: After reset, identification reads 0x01, line status reads 0x60 while the transmitter reports empty and idle, `irq` is low, and the interrupt enable, line control, modem control, scratch, mode and FIFO enable registers are all zero.
- R2: Interrupt enable (offset 1, bits 3:0), line control (offset 3, 8 bits), modem control (offset 4, bits 4:0), scratch (offset 7, 8 bits) and mode (offset 8, bits 2:0) read back what was written, with unimplemented bits reading 0. Line control bits drive `word_len`=[1:0], `stop2`=[2], `par_en`=[3], `par_even`=[4], `par_stick`=[5] and `break_on`=[6].
- R3: While line control bit 7 is 1, offsets 0 and 1 read and write the divisor low and high bytes. These writes cause no transmit push and leave the interrupt enable unchanged. `divisor` is {high, low}.
- R4: A write to offset 0 with line control bit 7 at 0 pulses `tx_push` for one cycle with `tx_data` equal to the written byte. A read returns `rx_data` and pulses `rx_pop` only when `rx_avail` is 1.
- R5: A write to offset 2 sets the FIFO enable from bit 0 and the receive trigger select from bits 7:6 (0=1, 1=4, 2=8, 3=14 bytes). Bit 1 pulses `rx_clr` and bit 2 pulses `tx_clr`. Any change of the enable pulses both clears. While the FIFOs are enabled, identification bits 7:6 read 11.
- R6: Line status (offset 5) is {fifo error, tx idle, holding empty, break, framing, parity, overrun, data ready} from bit 7 down to bit 0. The break, framing, parity and overrun bits are sticky and are cleared by a read of offset 5.
- R7: Modem status (offset 6) has the current DCD, RI, DSR and CTS in bits 7..4. Bits 0..3 are sticky flags for a CTS change, a DSR change, a falling edge of RI and a DCD change. A read of offset 6 clears these flags.
- R8: The identification code in bits 3:0 follows this priority, highest first: line status error 0x6, received data 0x4, character timeout 0xC, holding empty 0x2, modem change 0x0. It reads 0x1 when no enabled cause is pending.
- R9: The received-data cause (enable bit 0) is pending when `rx_avail` is 1 with the FIFOs off. With the FIFOs on, it is pending when `rx_count` reaches the selected trigger.
- R10: A `rx_timeout` pulse latches a timeout cause (enable bit 0). The cause stays set until a receive pop or a receive clear.
- R11: The holding-empty cause (enable bit 1) is set when `tx_hold_empty` rises, or when enable bit 1 is turned on while the holding register is empty. It is cleared by a read of offset 2 that reports it, or by a transmit write.
- R12: Modem control bit 4 selects loopback. In loopback, `dtr_out` and `rts_out` are forced low. CTS reads RTS (bit 1), DSR reads DTR (bit 0), RI reads bit 2 and DCD reads bit 3, and the modem pins are ignored. Outside loopback, `dtr_out` and `rts_out` follow bits 0 and 1.
- R13: `irq` is high exactly when identification bit 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq | output | 1 | Interrupt request |
| rx_data | input | 8 | Head byte of the receive FIFO |
| rx_avail | input | 1 | Receive data ready |
| rx_count | input | CW | Receive FIFO fill level |
| rx_timeout | input | 1 | Character timeout pulse |
| rx_overrun | input | 1 | Overrun pulse |
| rx_parity_err | input | 1 | Parity error pulse |
| rx_frame_err | input | 1 | Framing error pulse |
| rx_break | input | 1 | Break detected pulse |
| rx_fifo_err | input | 1 | Some FIFO entry carries an error |
| rx_pop | output | 1 | Receive FIFO pop |
| rx_clr | output | 1 | Receive FIFO clear |
| tx_hold_empty | input | 1 | Transmit holding space empty |
| tx_idle | input | 1 | Transmitter fully empty |
| tx_push | output | 1 | Transmit FIFO push |
| tx_data | output | 8 | Byte to push |
| tx_clr | output | 1 | Transmit FIFO clear |
| cts_in | input | 1 | Clear to send pin |
| dsr_in | input | 1 | Data set ready pin |
| ri_in | input | 1 | Ring indicator pin |
| dcd_in | input | 1 | Carrier detect pin |
| dtr_out | output | 1 | Data terminal ready |
| rts_out | output | 1 | Request to send |
| word_len | output | 2 | Word length code |
| stop2 | output | 1 | Two stop bits |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity |
| par_stick | output | 1 | Stick parity |
| break_on | output | 1 | Force break |
| divisor | output | 16 | Baud divisor |
| fifo_en | output | 1 | FIFOs enabled |
| rx_trig | output | 2 | Receive trigger select |
| loopback | output | 1 | Loopback mode |
| mode_sel | output | 3 | Mode register |

## Verification
The hardest case is the holding-empty cause. It is set on an edge and not on a level, and it can be cleared in two ways, one of which is only a read of the identification register at the moment that cause wins the priority. The stimulus drops `tx_hold_empty` and then raises it again, or turns enable bit 1 on while the register is empty. It then reads the identification register twice: the first read must report 0x2 and the second must report nothing. A separate pass clears the cause with a transmit write instead. The priority between causes is checked by stacking a line error on top of a received-data condition and watching the code fall back after the line status read.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq,
  input  logic [7:0]    rx_data,
  input  logic          rx_avail,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_timeout,
  input  logic          rx_overrun,
  input  logic          rx_parity_err,
  input  logic          rx_frame_err,
  input  logic          rx_break,
  input  logic          rx_fifo_err,
  output logic          rx_pop,
  output logic          rx_clr,
  input  logic          tx_hold_empty,
  input  logic          tx_idle,
  output logic          tx_push,
  output logic [7:0]    tx_data,
  output logic          tx_clr,
  input  logic          cts_in,
  input  logic          dsr_in,
  input  logic          ri_in,
  input  logic          dcd_in,
  output logic          dtr_out,
  output logic          rts_out,
  output logic [1:0]    word_len,
  output logic          stop2,
  output logic          par_en,
  output logic          par_even,
  output logic          par_stick,
  output logic          break_on,
  output logic [15:0]   divisor,
  output logic          fifo_en,
  output logic [1:0]    rx_trig,
  output logic          loopback,
  output logic [2:0]    mode_sel
);
  localparam logic [3:0] C_NONE = 4'h1, C_LS = 4'h6, C_RD = 4'h4,
                         C_TO = 4'hC, C_THR = 4'h2, C_MS = 4'h0;

  logic [3:0] ier;
  logic [7:0] lcr, scr, dll, dlm;
  logic [4:0] mcr;
  logic [2:0] mdr;
  logic [1:0] trig_sel;
  logic       oe_f, pe_f, fe_f, bi_f, to_f, thre_f, empty_prev, st_valid;
  logic [3:0] msr_d, st_prev, st_now, st_ev;
  logic [3:0] iir_code;
  logic [CW-1:0] trig_lvl;

  wire dlab   = lcr[7];
  wire loop   = mcr[4];
  wire w_thr  = wr_en && addr == 4'd0 && !dlab;
  wire w_ier  = wr_en && addr == 4'd1 && !dlab;
  wire w_fcr  = wr_en && addr == 4'd2;
  wire rd_iir = rd_en && addr == 4'd2;
  wire rd_lsr = rd_en && addr == 4'd5;
  wire rd_msr = rd_en && addr == 4'd6;
  wire rise   = tx_hold_empty && !empty_prev;
  wire ier_on = w_ier && wdata[1] && !ier[1] && tx_hold_empty;
  wire [7:0] lsr = {rx_fifo_err, tx_idle, tx_hold_empty, bi_f, fe_f, pe_f, oe_f, rx_avail};

  assign st_now = loop ? {mcr[3], mcr[2], mcr[0], mcr[1]} : {dcd_in, ri_in, dsr_in, cts_in};
  assign st_ev  = st_valid ? {st_now[3] ^ st_prev[3], st_prev[2] & ~st_now[2],
                              st_now[1] ^ st_prev[1], st_now[0] ^ st_prev[0]} : 4'b0;

  always_comb begin
    case (trig_sel)
      2'd0:    trig_lvl = CW'(1);
      2'd1:    trig_lvl = CW'(4);
      2'd2:    trig_lvl = CW'(8);
      default: trig_lvl = CW'(14);
    endcase
  end

  wire ls_p  = ier[2] && (oe_f || pe_f || fe_f || bi_f);
  wire rd_p  = ier[0] && (fifo_en ? rx_count >= trig_lvl : rx_avail);
  wire to_p  = ier[0] && to_f;
  wire thr_p = ier[1] && thre_f;
  wire ms_p  = ier[3] && |msr_d;

  always_comb begin
    if (ls_p)       iir_code = C_LS;
    else if (rd_p)  iir_code = C_RD;
    else if (to_p)  iir_code = C_TO;
    else if (thr_p) iir_code = C_THR;
    else if (ms_p)  iir_code = C_MS;
    else            iir_code = C_NONE;
  end

  always_comb begin
    case (addr)
      4'd0:    rdata = dlab ? dll : rx_data;
      4'd1:    rdata = dlab ? dlm : {4'b0, ier};
      4'd2:    rdata = {fifo_en, fifo_en, 2'b00, iir_code};
      4'd3:    rdata = lcr;
      4'd4:    rdata = {3'b0, mcr};
      4'd5:    rdata = lsr;
      4'd6:    rdata = {st_now, msr_d};
      4'd7:    rdata = scr;
      4'd8:    rdata = {5'b0, mdr};
      default: rdata = 8'h00;
    endcase
  end

  assign irq     = iir_code != C_NONE;
  assign rx_pop  = rd_en && addr == 4'd0 && !dlab && rx_avail;
  assign rx_clr  = w_fcr && (wdata[1] || wdata[0] != fifo_en);
  assign tx_clr  = w_fcr && (wdata[2] || wdata[0] != fifo_en);
  assign tx_push = w_thr;
  assign tx_data = wdata;
  assign dtr_out = mcr[0] && !loop;
  assign rts_out = mcr[1] && !loop;
  assign {break_on, par_stick, par_even, par_en, stop2, word_len} = lcr[6:0];
  assign divisor  = {dlm, dll};
  assign rx_trig  = trig_sel;
  assign loopback = loop;
  assign mode_sel = mdr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier <= '0; lcr <= '0; scr <= '0; dll <= '0; dlm <= '0; mcr <= '0; mdr <= '0;
      fifo_en <= 1'b0; trig_sel <= '0;
      oe_f <= 1'b0; pe_f <= 1'b0; fe_f <= 1'b0; bi_f <= 1'b0;
      to_f <= 1'b0; thre_f <= 1'b0; empty_prev <= 1'b0;
      msr_d <= '0; st_prev <= '0; st_valid <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          4'd0: if (dlab) dll <= wdata;
          4'd1: if (dlab) dlm <= wdata; else ier <= wdata[3:0];
          4'd2: begin fifo_en <= wdata[0]; trig_sel <= wdata[7:6]; end
          4'd3: lcr <= wdata;
          4'd4: mcr <= wdata[4:0];
          4'd7: scr <= wdata;
          4'd8: mdr <= wdata[2:0];
          default: ;
        endcase
      end
      oe_f <= (oe_f && !rd_lsr) || rx_overrun;
      pe_f <= (pe_f && !rd_lsr) || rx_parity_err;
      fe_f <= (fe_f && !rd_lsr) || rx_frame_err;
      bi_f <= (bi_f && !rd_lsr) || rx_break;
      msr_d <= (rd_msr ? 4'b0 : msr_d) | st_ev;
      st_prev <= st_now;
      st_valid <= 1'b1;
      empty_prev <= tx_hold_empty;
      if (rx_timeout) to_f <= 1'b1;
      else if (rx_pop || rx_clr) to_f <= 1'b0;
      if (rise || ier_on) thre_f <= 1'b1;
      else if (w_thr || (rd_iir && iir_code == C_THR)) thre_f <= 1'b0;
    end
  end

  assert_dlab_keeps_ier_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd1 && dlab) |=> $stable(ier));
  assert_flush_on_enable_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en != $past(fifo_en)) |-> $past(rx_clr && tx_clr));
  assert_lsr_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !(rx_overrun || rx_parity_err || rx_frame_err || rx_break))
    |=> !(oe_f || pe_f || fe_f || bi_f));
  assert_msr_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr && st_now == st_prev) |=> msr_d == 4'b0);
  assert_thr_write_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (w_thr && !rise && !ier_on) |=> !thre_f);
  assert_irq_needs_enable_R13: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ier != 4'b0);
endmodule

// File: tb/uart_regfile_bench.sv
module uart_regfile_bench;
  localparam int CW = 5;
  logic clk = 0, rst_n = 0;
  logic [3:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata, rx_data = 0, tx_data;
  logic irq, rx_avail = 0, rx_timeout = 0, rx_overrun = 0, rx_parity_err = 0;
  logic rx_frame_err = 0, rx_break = 0, rx_fifo_err = 0, rx_pop, rx_clr;
  logic [CW-1:0] rx_count = 0;
  logic tx_hold_empty = 1, tx_idle = 1, tx_push, tx_clr;
  logic cts_in = 0, dsr_in = 0, ri_in = 0, dcd_in = 0, dtr_out, rts_out;
  logic [1:0] word_len, rx_trig;
  logic stop2, par_en, par_even, par_stick, break_on, fifo_en, loopback;
  logic [15:0] divisor;
  logic [2:0] mode_sel;

  uart_regfile u_uart_regfile (.*);

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  int n_push = 0, n_pop = 0, n_rclr = 0, n_tclr = 0;
  logic [7:0] last_tx = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (tx_push) begin n_push++; last_tx = tx_data; end
    if (rx_pop) n_pop++;
    if (rx_clr) n_rclr++;
    if (tx_clr) n_tclr++;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1; #1 v = rdata;
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2, v); check("R1 iir", v, 8'h01);
    rd(5, v); check("R1 lsr", v, 8'h60);
    check("R1 irq", irq, 0);
    rd(1, v); check("R1 ier", v, 0);
    rd(3, v); check("R1 lcr", v, 0);
    rd(4, v); check("R1 mcr", v, 0);
    rd(7, v); check("R1 scr", v, 0);
    rd(8, v); check("R1 mode", v, 0);
    check("R1 fifo_en", fifo_en, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(1, 8'hFD); rd(1, v); check("R2 ier", v, 8'h0D); wr(1, 0);
    wr(3, 8'h1B); rd(3, v); check("R2 lcr", v, 8'h1B);
    check("R2 lcr fields", {break_on, par_stick, par_even, par_en, stop2, word_len}, 7'h1B);
    wr(4, 8'hE3); rd(4, v); check("R2 mcr", v, 8'h03);
    check("R12 dtr/rts normal", {dtr_out, rts_out}, 2'b11);
    wr(4, 0);
    wr(7, 8'hA5); rd(7, v); check("R2 scratch", v, 8'hA5);
    wr(8, 8'hFE); rd(8, v); check("R2 mode", v, 8'h06);
    check("R2 mode_sel", mode_sel, 3'h6);
  endtask

  task automatic t_dlab();
    logic [7:0] v;
    int p0;
    p0 = n_push;
    wr(3, 8'h83); wr(0, 8'h34); wr(1, 8'h12);
    check("R3 divisor", divisor, 16'h1234);
    check("R3 no push", n_push, p0);
    rd(0, v); check("R3 dll read", v, 8'h34);
    rd(1, v); check("R3 dlm read", v, 8'h12);
    wr(3, 8'h03);
    rd(1, v); check("R3 ier untouched", v, 0);
  endtask

  task automatic t_thr();
    wr(0, 8'h5A);
    check("R4 push count", n_push, 1);
    check("R4 tx_data", last_tx, 8'h5A);
  endtask

  task automatic t_thre();
    logic [7:0] v;
    @(negedge clk) tx_hold_empty = 0;
    wr(1, 8'h02); rd(2, v); check("R11 no cause while full", v, 8'h01);
    @(negedge clk) tx_hold_empty = 1; settle();
    check("R13 irq on thre", irq, 1);
    rd(2, v); check("R11 thre code", v, 8'h02);
    rd(2, v); check("R11 cleared by iir read", v, 8'h01);
    check("R13 irq low", irq, 0);
    @(negedge clk) tx_hold_empty = 0;
    @(negedge clk) tx_hold_empty = 1; settle();
    check("R11 rise sets", irq, 1);
    wr(0, 8'h11); settle();
    check("R11 cleared by thr write", irq, 0);
    wr(1, 0); wr(1, 8'h02);
    rd(2, v); check("R11 enable while empty", v, 8'h02);
    wr(1, 0);
  endtask

  task automatic t_rx();
    logic [7:0] v;
    int p0;
    wr(1, 8'h01);
    @(negedge clk) begin rx_data = 8'h77; rx_avail = 1; rx_count = 1; end
    rd(2, v); check("R9 rd cause no fifo", v, 8'h04);
    p0 = n_pop;
    rd(0, v); check("R4 rbr data", v, 8'h77);
    check("R4 pop", n_pop, p0 + 1);
    @(negedge clk) begin rx_avail = 0; rx_count = 0; end
    rd(0, v); check("R4 no pop when empty", n_pop, p0 + 1);
    rd(2, v); check("R8 none", v, 8'h01);
  endtask

  task automatic t_fifo();
    logic [7:0] v;
    int r0, t0;
    r0 = n_rclr; t0 = n_tclr;
    wr(2, 8'h81);
    check("R5 enable flush rx", n_rclr, r0 + 1);
    check("R5 enable flush tx", n_tclr, t0 + 1);
    check("R5 trig", rx_trig, 2);
    @(negedge clk) begin rx_avail = 1; rx_count = 5; end
    rd(2, v); check("R9 below trigger", v, 8'hC1);
    @(negedge clk) rx_count = 8;
    rd(2, v); check("R9 at trigger", v, 8'hC4);
    wr(2, 8'h83);
    check("R5 rx clear only", n_rclr, r0 + 2);
    check("R5 tx untouched", n_tclr, t0 + 1);
  endtask

  task automatic t_timeout();
    logic [7:0] v;
    @(negedge clk) begin rx_count = 5; rx_timeout = 1; end
    @(negedge clk) rx_timeout = 0;
    rd(2, v); check("R10 timeout code", v, 8'hCC);
    rd(2, v); check("R10 timeout holds", v, 8'hCC);
    rd(0, v);
    rd(2, v); check("R10 cleared by pop", v, 8'hC1);
  endtask

  task automatic t_lsr();
    logic [7:0] v;
    wr(1, 8'h05);
    @(negedge clk) begin rx_count = 8; rx_parity_err = 1; end
    @(negedge clk) rx_parity_err = 0;
    rd(2, v); check("R8 ls over rd", v, 8'hC6);
    rd(5, v); check("R6 parity bit", v, 8'h65);
    rd(5, v); check("R6 cleared", v, 8'h61);
    rd(2, v); check("R8 back to rd", v, 8'hC4);
    @(negedge clk) rx_overrun = 1;
    @(negedge clk) begin rx_overrun = 0; rx_fifo_err = 1; end
    rd(5, v); check("R6 overrun+fifo err", v, 8'hE3);
    @(negedge clk) rx_fifo_err = 0;
    rd(5, v); check("R6 overrun cleared", v, 8'h61);
    @(negedge clk) begin rx_avail = 0; rx_count = 0; end
    wr(1, 0);
  endtask

  task automatic t_modem();
    logic [7:0] v;
    wr(1, 8'h08);
    rd(6, v);
    @(negedge clk) cts_in = 1; settle();
    rd(6, v); check("R7 cts delta", v, 8'h11);
    rd(2, v); check("R8 modem code", v, 8'hC1);
    @(negedge clk) cts_in = 0; settle();
    rd(2, v); check("R8 modem pending", v, 8'hC0);
    rd(6, v); check("R7 cts fell", v, 8'h01);
    rd(6, v); check("R7 read clears", v, 8'h00);
    @(negedge clk) ri_in = 1; settle();
    rd(6, v); check("R7 ri rise no flag", v, 8'h40);
    @(negedge clk) ri_in = 0; settle();
    rd(6, v); check("R7 ri trailing", v, 8'h04);
    wr(1, 0);
  endtask

  task automatic t_loop();
    logic [7:0] v;
    wr(4, 8'h13);
    check("R12 outputs forced low", {dtr_out, rts_out}, 0);
    rd(6, v); check("R12 cts/dsr from mcr", v & 8'hF0, 8'h30);
    @(negedge clk) begin cts_in = 1; dcd_in = 1; end
    wr(4, 8'h11);
    rd(6, v); check("R12 pins ignored", v & 8'hF0, 8'h20);
    wr(4, 0);
    @(negedge clk) begin cts_in = 0; dcd_in = 0; end
    rd(6, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_regs(); t_dlab(); t_thr(); t_thre(); t_rx();
    t_fifo(); t_timeout(); t_lsr(); t_modem(); t_loop();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule